// File: doc/BRIEF.md
# Stream Core Run Control with End-of-Frame Tracking

This block sequences one direction of a programmable streaming engine. Software drives level controls for enable, pause, halt and halt mode, and single-cycle trigger pulses for FIFO flush and trace clear. The datapath reports write-back completion, end-of-frame arrival and per-byte beats on the DMA side and on the peripheral side. The block holds the core in one of four states (idle, run, wait, pause) and shows that state as four status flags, of which exactly one is set.

While the core runs, it counts byte beats on a selectable side. When an end-of-frame arrives, that count is captured into a status field. The block then processes a programmable number of tail bits, eight per beat. When the tail is used up, it pulses frame-done and returns to idle. A second end-of-frame that arrives while a capture is still held is dropped and raises a sticky overload flag. A trace-clear pulse releases the capture and clears both the count and the flag.

A small occupancy tracker follows the core FIFO. It shows empty for the transmit variant and full for the receive variant.

Top module: `strm_run_ctrl`

## Requirements
- R1: Exactly one of stat_idle, stat_run, stat_wait and stat_pause is 1 in every cycle.
- R2: After a synchronous reset the core is idle: stat_idle=1, stat_eof_cnt=0, stat_eof_ovf=0 and frame_done=0. The FIFO is empty, so stat_fifo=1 for the transmit variant (IS_RX=0) and stat_fifo=0 for the receive variant (IS_RX=1).
- R3: From idle, the core enters run on the next clock edge only if ctl_enable=1 and ctl_halt=0. Otherwise it stays idle.
- R4: In run or pause, ctl_halt=1 with ctl_halt_mode=0 moves the core to wait. The core leaves wait for idle on the edge where dp_wb_done=1 or ctl_halt_mode=1.
- R5: In run or pause, ctl_halt=1 with ctl_halt_mode=1 moves the core straight to idle on the next edge, whatever dp_wb_done is. Halt takes priority over pause and over frame completion.
- R6: In run, ctl_pause=1 with ctl_halt=0 moves the core to pause. In pause, ctl_pause=0 with ctl_halt=0 moves it back to run.
- R7: A byte counter of CNT_W bits is zeroed on each idle-to-run step. It counts, modulo 2^CNT_W, the beats seen in run on the selected side: dma_beat when ctl_eof_side=0, per_beat when ctl_eof_side=1. When dp_eof=1 in run and no capture is held, the counter value from before that cycle is copied to stat_eof_cnt and a capture becomes held.
- R8: When dp_eof=1 in run while a capture is held, stat_eof_ovf becomes 1 and stays 1. stat_eof_cnt is unchanged and the tail is not reloaded. dp_eof has no effect outside run.
- R9: ctl_trace_clr=1 clears stat_eof_cnt and stat_eof_ovf and releases the capture on the next edge. A dp_eof in the same cycle is judged as if no capture were held.
- R10: A captured end-of-frame loads the tail with ctl_tail_bits. Each selected beat in run then takes 8 off the tail, never going below 0. In run with the tail at 0 and no halt or pause, the core goes idle on the next edge, and frame_done is 1 for exactly that cycle.
- R11: The FIFO level is pushed by dma_beat and popped by per_beat in the transmit variant, and the reverse in the receive variant. A push at level FIFO_DEPTH or a pop at level 0 is dropped. ctl_fifo_flush sets the level to 0. stat_fifo reads level==0 in the transmit variant and level==FIFO_DEPTH in the receive variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_enable | input | 1 | Allows the core to leave idle |
| ctl_pause | input | 1 | Requests the pause state |
| ctl_halt | input | 1 | Requests the core to stop |
| ctl_halt_mode | input | 1 | 0: wait for write-back, 1: stop at once |
| ctl_eof_side | input | 1 | Beat side used for counting: 0 DMA, 1 peripheral |
| ctl_tail_bits | input | TAIL_W | Tail bits to process after end-of-frame |
| ctl_fifo_flush | input | 1 | Trigger pulse that empties the FIFO level |
| ctl_trace_clr | input | 1 | Trigger pulse that clears the capture and overload |
| dp_wb_done | input | 1 | Write-back finished |
| dp_eof | input | 1 | End-of-frame seen |
| dma_beat | input | 1 | One byte moved on the DMA side |
| per_beat | input | 1 | One byte moved on the peripheral side |
| stat_idle | output | 1 | Core idle (halted) |
| stat_run | output | 1 | Core running |
| stat_wait | output | 1 | Core waiting for write-back |
| stat_pause | output | 1 | Core paused |
| stat_fifo | output | 1 | FIFO empty (transmit) or full (receive) |
| stat_eof_cnt | output | CNT_W | Byte count captured at end-of-frame |
| stat_eof_ovf | output | 1 | An end-of-frame was lost |
| frame_done | output | 1 | One-cycle pulse when the tail is done |

## Verification
A wrong state register shows up on the status flags one edge after the wrong input. A late or missed transition appears as a flag that lingers or jumps for a single cycle. A fault in the byte counter or in capture gating stays hidden until the next captured end-of-frame, and then stat_eof_cnt is wrong in that cycle. A bad tail decrement does not corrupt any value directly. It moves frame_done and the return to idle earlier or later by one or more beats, so the bench compares every output in every cycle against a step model, which exposes a change in that timing.

// File: rtl/strm_run_pkg.sv
package strm_run_pkg;

    localparam int BYTE_BITS = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_WAIT  = 2'd2,
        ST_PAUSE = 2'd3
    } run_state_e;

    typedef struct packed {
        logic idle;
        logic run;
        logic wait_wb;
        logic pause;
    } run_status_t;

    function automatic run_status_t decode_status(run_state_e s);
        run_status_t r;
        r.idle    = (s == ST_IDLE);
        r.run     = (s == ST_RUN);
        r.wait_wb = (s == ST_WAIT);
        r.pause   = (s == ST_PAUSE);
        return r;
    endfunction

    // state reached when a halt request is taken
    function automatic run_state_e halt_target(logic immediate);
        return immediate ? ST_IDLE : ST_WAIT;
    endfunction

endpackage

// File: rtl/strm_run_fsm.sv
module strm_run_fsm
    import strm_run_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       pause,
    input  logic       halt,
    input  logic       halt_mode,
    input  logic       wb_done,
    input  logic       tail_done,
    output run_state_e state,
    output logic       run_start,
    output logic       frame_done
);
    run_state_e nxt;
    logic       finish;

    assign finish    = (state == ST_RUN) && !halt && !pause && tail_done;
    assign run_start = (state == ST_IDLE) && enable && !halt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (run_start) nxt = ST_RUN;
            ST_RUN: begin
                if (halt)        nxt = halt_target(halt_mode);
                else if (pause)  nxt = ST_PAUSE;
                else if (finish) nxt = ST_IDLE;
            end
            ST_PAUSE: begin
                if (halt)        nxt = halt_target(halt_mode);
                else if (!pause) nxt = ST_RUN;
            end
            ST_WAIT: if (wb_done || halt_mode) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            frame_done <= 1'b0;
        end else begin
            state      <= nxt;
            frame_done <= finish;
        end
    end

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && !wb_done && !halt_mode) |=> (state == ST_WAIT)); // R4
    AST_HALT_NOW: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_RUN || state == ST_PAUSE) && halt && halt_mode) |=> (state == ST_IDLE)); // R5
    AST_PAUSE_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && pause && !halt) |=> (state == ST_PAUSE)); // R6
    AST_IDLE_GATE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && (!enable || halt)) |=> (state == ST_IDLE)); // R3

endmodule

// File: rtl/strm_eof_track.sv
module strm_eof_track
    import strm_run_pkg::*;
#(
    parameter int CNT_W  = 14,
    parameter int TAIL_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_run,
    input  logic              in_idle,
    input  logic              run_start,
    input  logic              beat,
    input  logic              eof,
    input  logic              clr,
    input  logic [TAIL_W-1:0] tail_cfg,
    output logic [CNT_W-1:0]  eof_cnt,
    output logic              eof_ovf,
    output logic              tail_done
);
    localparam logic [TAIL_W-1:0] STEP = TAIL_W'(BYTE_BITS);

    logic [CNT_W-1:0]  byte_cnt;
    logic [TAIL_W-1:0] tail_left;
    logic              tail_act;
    logic              cap_held;
    logic              held_eff;
    logic              take_eof;
    logic              lose_eof;

    assign held_eff  = cap_held && !clr;
    assign take_eof  = in_run && eof && !held_eff;
    assign lose_eof  = in_run && eof && held_eff;
    assign tail_done = tail_act && (tail_left == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_cnt <= '0;
        end else if (run_start) begin
            byte_cnt <= '0;
        end else if (in_run && beat) begin
            byte_cnt <= byte_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eof_cnt  <= '0;
            eof_ovf  <= 1'b0;
            cap_held <= 1'b0;
        end else begin
            if (clr) begin
                eof_cnt  <= '0;
                eof_ovf  <= 1'b0;
                cap_held <= 1'b0;
            end
            if (take_eof) begin
                eof_cnt  <= byte_cnt;
                cap_held <= 1'b1;
            end
            if (lose_eof) eof_ovf <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || in_idle) begin
            tail_left <= '0;
            tail_act  <= 1'b0;
        end else if (take_eof) begin
            tail_left <= tail_cfg;
            tail_act  <= 1'b1;
        end else if (in_run && tail_act && beat) begin
            tail_left <= (tail_left > STEP) ? tail_left - STEP : '0;
        end
    end

    AST_LOST_EOF: assert property (@(posedge clk) disable iff (rst)
        lose_eof |=> (eof_ovf && $stable(eof_cnt))); // R8
    AST_TRACE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr && !(in_run && eof)) |=> (eof_cnt == '0 && !eof_ovf)); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (eof_ovf && !clr) |=> eof_ovf); // R8

endmodule

// File: rtl/strm_fifo_level.sv
module strm_fifo_level #(
    parameter int DEPTH = 16,
    parameter bit IS_RX = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic dma_beat,
    input  logic per_beat,
    output logic flag
);
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [LVL_W-1:0] TOP = LVL_W'(DEPTH);

    logic [LVL_W-1:0] level;
    logic push, pop, push_ok, pop_ok;

    generate
        if (IS_RX) begin : g_rx
            assign push = per_beat;
            assign pop  = dma_beat;
            assign flag = (level == TOP);
        end else begin : g_tx
            assign push = dma_beat;
            assign pop  = per_beat;
            assign flag = (level == '0);
        end
    endgenerate

    assign push_ok = push && (level != TOP);
    assign pop_ok  = pop && (level != '0);

    always_ff @(posedge clk) begin
        if (rst || flush) level <= '0;
        else level <= level + LVL_W'(push_ok) - LVL_W'(pop_ok);
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        level <= TOP); // R11
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> (level == '0)); // R11

endmodule

// File: rtl/strm_run_ctrl.sv
module strm_run_ctrl
    import strm_run_pkg::*;
#(
    parameter int CNT_W      = 14,
    parameter int TAIL_W     = 16,
    parameter int FIFO_DEPTH = 16,
    parameter bit IS_RX      = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_enable,
    input  logic              ctl_pause,
    input  logic              ctl_halt,
    input  logic              ctl_halt_mode,
    input  logic              ctl_eof_side,
    input  logic [TAIL_W-1:0] ctl_tail_bits,
    input  logic              ctl_fifo_flush,
    input  logic              ctl_trace_clr,
    input  logic              dp_wb_done,
    input  logic              dp_eof,
    input  logic              dma_beat,
    input  logic              per_beat,
    output logic              stat_idle,
    output logic              stat_run,
    output logic              stat_wait,
    output logic              stat_pause,
    output logic              stat_fifo,
    output logic [CNT_W-1:0]  stat_eof_cnt,
    output logic              stat_eof_ovf,
    output logic              frame_done
);
    run_state_e  state;
    run_status_t status;
    logic        run_start;
    logic        tail_done;
    logic        sel_beat;

    assign sel_beat = ctl_eof_side ? per_beat : dma_beat;

    strm_run_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .enable     (ctl_enable),
        .pause      (ctl_pause),
        .halt       (ctl_halt),
        .halt_mode  (ctl_halt_mode),
        .wb_done    (dp_wb_done),
        .tail_done  (tail_done),
        .state      (state),
        .run_start  (run_start),
        .frame_done (frame_done)
    );

    strm_eof_track #(.CNT_W(CNT_W), .TAIL_W(TAIL_W)) u_eof (
        .clk       (clk),
        .rst       (rst),
        .in_run    (state == ST_RUN),
        .in_idle   (state == ST_IDLE),
        .run_start (run_start),
        .beat      (sel_beat),
        .eof       (dp_eof),
        .clr       (ctl_trace_clr),
        .tail_cfg  (ctl_tail_bits),
        .eof_cnt   (stat_eof_cnt),
        .eof_ovf   (stat_eof_ovf),
        .tail_done (tail_done)
    );

    strm_fifo_level #(.DEPTH(FIFO_DEPTH), .IS_RX(IS_RX)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .flush    (ctl_fifo_flush),
        .dma_beat (dma_beat),
        .per_beat (per_beat),
        .flag     (stat_fifo)
    );

    assign status     = decode_status(state);
    assign stat_idle  = status.idle;
    assign stat_run   = status.run;
    assign stat_wait  = status.wait_wb;
    assign stat_pause = status.pause;

    AST_DONE_IN_IDLE: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> stat_idle); // R10
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done); // R10

endmodule

// File: tb/strm_run_ctrl_tb.sv
module strm_run_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 14;
    localparam int TAIL_W = 16;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 0, pz = 0, hl = 0, hm = 0, side = 0, fl = 0, tc = 0, wb = 0, eof = 0, db = 0, pb = 0;
    logic [TAIL_W-1:0] tail = '0;

    logic s_idle, s_run, s_wait, s_pause, s_fifo, s_ovf, s_fd;
    logic [CNT_W-1:0] s_cnt;
    logic r_idle, r_run, r_wait, r_pause, r_fifo, r_ovf, r_fd;
    logic [CNT_W-1:0] r_cnt;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    // model state: 0 idle, 1 run, 2 wait, 3 pause
    int m_st, m_bcnt, m_ecnt, m_tail, m_ltx, m_lrx;
    bit m_ovf, m_held, m_act, m_fd;
    string st_tag, cnt_tag, ovf_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    strm_run_ctrl #(.CNT_W(CNT_W), .TAIL_W(TAIL_W), .FIFO_DEPTH(DEPTH), .IS_RX(1'b0)) u_dut (
        .clk(clk), .rst(rst), .ctl_enable(en), .ctl_pause(pz), .ctl_halt(hl), .ctl_halt_mode(hm),
        .ctl_eof_side(side), .ctl_tail_bits(tail), .ctl_fifo_flush(fl), .ctl_trace_clr(tc),
        .dp_wb_done(wb), .dp_eof(eof), .dma_beat(db), .per_beat(pb),
        .stat_idle(s_idle), .stat_run(s_run), .stat_wait(s_wait), .stat_pause(s_pause),
        .stat_fifo(s_fifo), .stat_eof_cnt(s_cnt), .stat_eof_ovf(s_ovf), .frame_done(s_fd));

    strm_run_ctrl #(.CNT_W(CNT_W), .TAIL_W(TAIL_W), .FIFO_DEPTH(DEPTH), .IS_RX(1'b1)) u_dut_rx (
        .clk(clk), .rst(rst), .ctl_enable(en), .ctl_pause(pz), .ctl_halt(hl), .ctl_halt_mode(hm),
        .ctl_eof_side(side), .ctl_tail_bits(tail), .ctl_fifo_flush(fl), .ctl_trace_clr(tc),
        .dp_wb_done(wb), .dp_eof(eof), .dma_beat(db), .per_beat(pb),
        .stat_idle(r_idle), .stat_run(r_run), .stat_wait(r_wait), .stat_pause(r_pause),
        .stat_fifo(r_fifo), .stat_eof_cnt(r_cnt), .stat_eof_ovf(r_ovf), .frame_done(r_fd));

    task automatic check(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int lvl_next(int lvl, bit push, bit pop);
        int r = lvl;
        if (push && lvl != DEPTH) r++;
        if (pop && lvl != 0) r--;
        return r;
    endfunction

    function automatic int tail_step(int t);
        return (t > 8) ? t - 8 : 0;
    endfunction

    task automatic model_update();
        bit sel, in_run, start, held_eff, fin;
        int nst;
        if (rst) begin
            m_st = 0; m_bcnt = 0; m_ecnt = 0; m_tail = 0; m_ltx = 0; m_lrx = 0;
            m_ovf = 0; m_held = 0; m_act = 0; m_fd = 0;
            st_tag = "R2"; cnt_tag = "R2"; ovf_tag = "R2";
            return;
        end
        sel = side ? pb : db;
        in_run = (m_st == 1);
        start = (m_st == 0) && en && !hl;
        fin = in_run && !hl && !pz && m_act && (m_tail == 0);
        nst = m_st;
        st_tag = "R3";
        case (m_st)
            0: if (start) nst = 1;
            1: begin
                if (hl) begin nst = hm ? 0 : 2; st_tag = hm ? "R5" : "R4"; end
                else if (pz) begin nst = 3; st_tag = "R6"; end
                else if (fin) begin nst = 0; st_tag = "R10"; end
            end
            3: begin
                if (hl) begin nst = hm ? 0 : 2; st_tag = hm ? "R5" : "R4"; end
                else begin st_tag = "R6"; if (!pz) nst = 1; end
            end
            default: begin st_tag = "R4"; if (wb || hm) nst = 0; end
        endcase
        held_eff = m_held && !tc;
        cnt_tag = tc ? "R9" : "R7";
        ovf_tag = tc ? "R9" : "R8";
        if (tc) begin m_ecnt = 0; m_ovf = 0; m_held = 0; end
        if (m_st == 0) begin
            m_act = 0; m_tail = 0;
        end else if (in_run && eof && !held_eff) begin
            m_ecnt = m_bcnt; m_held = 1; m_tail = int'(tail); m_act = 1;
        end else if (in_run && m_act && sel) begin
            m_tail = tail_step(m_tail);
        end
        if (in_run && eof && held_eff) m_ovf = 1;
        if (start) m_bcnt = 0;
        else if (in_run && sel) m_bcnt = (m_bcnt + 1) % (1 << CNT_W);
        if (fl) begin m_ltx = 0; m_lrx = 0; end
        else begin m_ltx = lvl_next(m_ltx, db, pb); m_lrx = lvl_next(m_lrx, pb, db); end
        m_fd = fin;
        m_st = nst;
    endtask

    task automatic compare_all();
        check("R1", "one-hot status", $countones({s_idle, s_run, s_wait, s_pause}), 1);
        check(st_tag, "state", {30'd0, s_pause | s_wait, s_pause | s_run}, m_st);
        check(cnt_tag, "eof count", int'(s_cnt), m_ecnt);
        check(ovf_tag, "overload", int'(s_ovf), int'(m_ovf));
        check("R10", "frame_done", int'(s_fd), int'(m_fd));
        check("R11", "tx fifo empty", int'(s_fifo), int'(m_ltx == 0));
        check("R11", "rx fifo full", int'(r_fifo), int'(m_lrx == DEPTH));
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        #1;
        compare_all();
    endtask

    task automatic clear_pulses();
        fl = 0; tc = 0; eof = 0; wb = 0; db = 0; pb = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1;
        step(); step();
        rst = 0;
        #1;
        // R2: reset values
        check("R2", "idle after reset", int'(s_idle), 1);
        check("R2", "tx empty after reset", int'(s_fifo), 1);
        check("R2", "rx not full after reset", int'(r_fifo), 0);
        check("R2", "count after reset", int'(s_cnt), 0);

        // R3: no start while disabled or halted
        step(); step();
        en = 1; hl = 1; step();
        check("R3", "halted stays idle", int'(s_idle), 1);
        hl = 0; step();
        check("R3", "start", int'(s_run), 1);

        // R7/R10: five beats, eof with tail 16, two beats finish
        side = 0; db = 1;
        repeat (5) step();
        db = 0; eof = 1; tail = 16; step();
        eof = 0;
        check("R7", "captured beats", int'(s_cnt), 5);
        db = 1; step(); step();
        db = 0; step();
        check("R10", "frame done pulse", int'(s_fd), 1);
        step();
        // R8: held capture, next eof lost
        eof = 1; step(); eof = 0; step();
        check("R8", "lost eof", int'(s_ovf), 1);
        // R9: clear with simultaneous eof
        tc = 1; eof = 1; step(); clear_pulses();
        check("R9", "ovf cleared", int'(s_ovf), 0);
        // R4: halt waiting for write-back
        hl = 1; hm = 0; step(); step(); step();
        check("R4", "waiting", int'(s_wait), 1);
        wb = 1; step(); wb = 0;
        check("R4", "idle after wb", int'(s_idle), 1);
        hl = 0; step();
        // R6 then R5
        pz = 1; step(); step();
        check("R6", "paused", int'(s_pause), 1);
        hl = 1; hm = 1; step();
        check("R5", "immediate idle", int'(s_idle), 1);
        hl = 0; pz = 0; tc = 1; step(); tc = 0;
        // tail of zero
        eof = 1; tail = 0; step(); eof = 0; step();
        check("R10", "zero tail done", int'(s_fd), 1);
        // R11: fill the fifo
        side = 1; db = 1; repeat (DEPTH + 2) step(); db = 0;
        pb = 1; repeat (3) step(); pb = 0;
        fl = 1; step(); fl = 0; step();

        // random phase
        for (int i = 0; i < 4000; i++) begin
            clear_pulses();
            if ($urandom_range(19) == 0) hl = ~hl;
            if ($urandom_range(15) == 0) pz = ~pz;
            if ($urandom_range(9) == 0) hm = $urandom_range(1);
            if ($urandom_range(31) == 0) en = ~en;
            if ($urandom_range(63) == 0) side = ~side;
            wb = ($urandom_range(3) == 0);
            eof = ($urandom_range(19) == 0);
            tc = ($urandom_range(39) == 0);
            fl = ($urandom_range(63) == 0);
            db = $urandom_range(1);
            pb = $urandom_range(1);
            tail = TAIL_W'($urandom_range(40));
            step();
        end
        clear_pulses();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule